// File: doc/BRIEF.md
# Receive Data-Valid Detector

This block decides, on the reference clock, whether a radio receiver is currently seeing usable data. It combines two tests. The first is a timing test. A counter measures how many reference-clock cycles separate edges of the sliced data stream, and that count must fall inside a programmable window. The second is a signal-strength test. A digitized level must exceed a 6-bit threshold. The result is latched into a registered flag only at the moment a measurement completes, and the flag holds its value between measurements.

Detection stays disabled for a fixed settling interval after the receive path is switched on. When the flag rises, an active-low wake pulse of fixed length is issued so that a sleeping controller can be roused. The comparator level can be taken from the received-strength code or from a supply-reference code. Setting the threshold to all ones removes the strength test entirely. The window can measure either the full period (rising edge to rising edge) or the high time (rising edge to falling edge). Slicer, converter and register access lie outside the block, and their values arrive as plain inputs.

Top module: `rxdv_top`

## Requirements
- R1: `data_valid` becomes 1 only at a measurement completion where the measured count lies in the window and the strength test passes; either test failing at a completion makes it 0.
- R2: With `meas_high`=0 the measured count is the number of clock cycles between two successive rising edges of the synchronized data; a data stream with 128-cycle rising-edge spacing fails a 60..70 window and passes a 120..130 window.
- R3: `data_valid` changes only at a measurement completion; with no data edges it holds its value even when the strength inputs change.
- R4: `data_valid` stays 0 until `rx_en` has been high for `SETTLE_CYCLES` consecutive clock cycles.
- R5: The strength test passes only when the selected level is strictly greater than `rssi_thr`. For example, a level of 30 against a threshold of 30 fails, and 31 passes.
- R6: `rssi_thr` = 6'b111111 disables the strength test, which then always passes.
- R7: When `data_valid` goes from 0 to 1, `wake_n` goes low on the same clock edge and stays low for exactly `PULSE_CYCLES` cycles.
- R8: `thr_sel`=0 compares `rssi_code`, and `thr_sel`=1 compares `vcc_code`.
- R9: Window limits are inclusive. A count equal to `win_lo` or to `win_hi` passes, and a count one below `win_lo` or one above `win_hi` fails.
- R10: With `meas_high`=1 the measured count is the number of cycles from a rising edge to the following falling edge.
- R11: A clock edge that samples `rx_en`=0 clears `data_valid` to 0 and returns `wake_n` to 1.
- R12: After reset, `data_valid` is 0 and `wake_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive path active |
| data_in | input | 1 | Sliced data, asynchronous to clk |
| meas_high | input | 1 | 0: measure period, 1: measure high time |
| win_lo | input | CNT_W | Lower window limit (inclusive) |
| win_hi | input | CNT_W | Upper window limit (inclusive) |
| rssi_code | input | RSSI_W | Digitized received-strength level |
| vcc_code | input | RSSI_W | Digitized supply-reference level |
| thr_sel | input | 1 | Selects the level compared against the threshold |
| rssi_thr | input | RSSI_W | Strength threshold; all ones disables the test |
| data_valid | output | 1 | Registered data-valid flag |
| wake_n | output | 1 | Active-low wake pulse |

## Verification
The hardest state to reach is a flag that is already set while the strength inputs move and no measurement completes. Only that state separates "latched at completion" from "follows the compare". The bench first brings up a valid flag with a steady Manchester preamble. It then freezes the data line for several bit times, drops the strength level below threshold, and confirms that the flag holds. Finally it resumes edges and sees the flag fall. Window boundaries are hit exactly because the generator toggles on fixed clock counts, which makes the period and the high time exact integers that can sit on each limit.

// File: rtl/rxdv_pkg.sv
`timescale 1ns/1ps
package rxdv_pkg;
  typedef enum logic {
    MEAS_PERIOD = 1'b0,
    MEAS_HIGH   = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/rxdv_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes the sliced data and flags its edges one cycle after the last stage.
module rxdv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/rxdv_settle_timer.sv
`timescale 1ns/1ps
// Holds detection off until rx_en has been high for SETTLE_CYCLES cycles.
module rxdv_settle_timer #(
  parameter int SETTLE_CYCLES = 49562
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  output logic armed
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (cnt == SW'(SETTLE_CYCLES - 1)) armed <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxdv_window_counter.sv
`timescale 1ns/1ps
// Counts clock cycles between data edges and strobes done with the count.
module rxdv_window_counter
  import rxdv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  meas_mode_e       mode,
  input  logic             rise,
  input  logic             fall,
  output logic             done,
  output logic [CNT_W-1:0] meas
);
  logic [CNT_W-1:0] wcnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      wcnt    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
      meas    <= '0;
    end else begin
      done <= 1'b0;
      if (running && (wcnt != '1)) wcnt <= wcnt + 1'b1;
      if (mode == MEAS_PERIOD) begin
        if (rise) begin
          if (running) begin
            done <= 1'b1;
            meas <= wcnt;
          end
          running <= 1'b1;
          wcnt    <= CNT_W'(1);
        end
      end else begin
        if (rise) begin
          running <= 1'b1;
          wcnt    <= CNT_W'(1);
        end else if (fall && running) begin
          done    <= 1'b1;
          meas    <= wcnt;
          running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rxdv_rssi_gate.sv
`timescale 1ns/1ps
// Registered strength compare; an all-ones threshold bypasses the test.
module rxdv_rssi_gate #(
  parameter int RSSI_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [RSSI_W-1:0] rssi_code,
  input  logic [RSSI_W-1:0] vcc_code,
  input  logic [RSSI_W-1:0] thr,
  output logic              pass
);
  logic [RSSI_W-1:0] level;
  assign level = sel ? vcc_code : rssi_code;

  always_ff @(posedge clk) begin
    if (rst) pass <= 1'b0;
    else     pass <= (thr == {RSSI_W{1'b1}}) || (level > thr);
  end
endmodule

// File: rtl/rxdv_wake_pulse.sv
`timescale 1ns/1ps
// Drives an active-low pulse of PULSE_CYCLES cycles from a start strobe.
module rxdv_wake_pulse #(
  parameter int PULSE_CYCLES = 286
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic wake_n
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt   <= '0;
      wake_n <= 1'b1;
    end else if (start) begin
      pcnt   <= PW'(PULSE_CYCLES - 1);
      wake_n <= 1'b0;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - 1'b1;
    end else begin
      wake_n <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdv_checker.sv
`timescale 1ns/1ps
module rxdv_checker #(
  parameter int SETTLE_CYCLES = 49562,
  parameter int PULSE_CYCLES  = 286
) (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic data_valid,
  input logic wake_n,
  input logic win_done,
  input logic rssi_pass
);
  int age;
  int low_run;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) age <= 0;
    else if (age < SETTLE_CYCLES) age <= age + 1;
    if (rst || wake_n) low_run <= 0;
    else               low_run <= low_run + 1;
  end

  AST_WAKE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> !wake_n); // R7
  AST_WAKE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !wake_n |-> (low_run < PULSE_CYCLES)); // R7
  AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!data_valid && wake_n)); // R11
  AST_SETTLE_GUARD: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (age >= SETTLE_CYCLES)); // R4
  AST_RISE_AT_COMPLETION: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> $past(win_done)); // R3
  AST_RISE_NEEDS_RSSI: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> $past(rssi_pass)); // R1
endmodule

bind rxdv_top rxdv_checker #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .data_valid(data_valid),
  .wake_n    (wake_n),
  .win_done  (win_done),
  .rssi_pass (rssi_pass)
);

// File: rtl/rxdv_top.sv
`timescale 1ns/1ps
module rxdv_top
  import rxdv_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int RSSI_W        = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 49562,
  parameter int PULSE_CYCLES  = 286
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              data_in,
  input  logic              meas_high,
  input  logic [CNT_W-1:0]  win_lo,
  input  logic [CNT_W-1:0]  win_hi,
  input  logic [RSSI_W-1:0] rssi_code,
  input  logic [RSSI_W-1:0] vcc_code,
  input  logic              thr_sel,
  input  logic [RSSI_W-1:0] rssi_thr,
  output logic              data_valid,
  output logic              wake_n
);
  logic             rise, fall, armed, win_done, rssi_pass, in_window, set_evt;
  logic [CNT_W-1:0] win_meas;
  meas_mode_e       mode;

  assign mode = meas_mode_e'(meas_high);

  rxdv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(data_in), .rise(rise), .fall(fall)
  );

  rxdv_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .rx_en(rx_en), .armed(armed)
  );

  rxdv_window_counter #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .armed(armed), .mode(mode),
    .rise(rise), .fall(fall), .done(win_done), .meas(win_meas)
  );

  rxdv_rssi_gate #(.RSSI_W(RSSI_W)) u_rssi (
    .clk(clk), .rst(rst), .sel(thr_sel), .rssi_code(rssi_code),
    .vcc_code(vcc_code), .thr(rssi_thr), .pass(rssi_pass)
  );

  assign in_window = (win_meas >= win_lo) && (win_meas <= win_hi);
  assign set_evt   = rx_en && win_done && in_window && rssi_pass && !data_valid;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)  data_valid <= 1'b0;
    else if (win_done)  data_valid <= in_window && rssi_pass;
  end

  rxdv_wake_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .clr(!rx_en), .start(set_evt), .wake_n(wake_n)
  );
endmodule

// File: tb/rxdv_top_tb.sv
`timescale 1ns/1ps
module rxdv_top_tb;
  localparam int CW     = 12;
  localparam int SETTLE = 300;
  localparam int PULSE  = 40;
  localparam int HB     = 32;   // half-bit in clock cycles (scaled 2 kbit/s Manchester)
  localparam int MAXW   = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, rx_en, data_in, meas_high, thr_sel;
  logic [CW-1:0] win_lo, win_hi;
  logic [5:0] rssi_code, vcc_code, rssi_thr;
  logic data_valid, wake_n;

  int checks = 0, fails = 0, cyc = 0;
  int first_valid = -1, low_run = 0, last_low = 0;

  always #2 clk = ~clk;

  rxdv_top #(.CNT_W(CW), .SETTLE_CYCLES(SETTLE), .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .data_in(data_in), .meas_high(meas_high),
    .win_lo(win_lo), .win_hi(win_hi), .rssi_code(rssi_code), .vcc_code(vcc_code),
    .thr_sel(thr_sel), .rssi_thr(rssi_thr), .data_valid(data_valid), .wake_n(wake_n)
  );

  // ---------------- behavioural reference model ----------------
  int  q[$];
  int  m_age, m_w, m_meas, m_pc;
  bit  m_armed, m_run, m_done, m_pass, m_valid, m_wake;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      q = '{0, 0, 0};
      m_age = 0; m_w = 0; m_meas = 0; m_pc = 0;
      m_armed = 0; m_run = 0; m_done = 0; m_pass = 0; m_valid = 0; m_wake = 1;
    end else begin
      bit rise, fall, n_done, n_run, n_pass, inwin, start;
      int n_w, n_meas;
      rise = (q[1] == 1) && (q[0] == 0);
      fall = (q[1] == 0) && (q[0] == 1);
      n_done = 0; n_w = m_w; n_run = m_run; n_meas = m_meas;
      if (!m_armed) begin
        n_w = 0; n_run = 0; n_meas = 0;
      end else begin
        if (m_run && m_w < MAXW) n_w = m_w + 1;
        if (!meas_high) begin
          if (rise) begin
            if (m_run) begin n_done = 1; n_meas = m_w; end
            n_run = 1; n_w = 1;
          end
        end else begin
          if (rise) begin n_run = 1; n_w = 1; end
          else if (fall && m_run) begin n_done = 1; n_meas = m_w; n_run = 0; end
        end
      end
      n_pass = (rssi_thr == 6'h3f) || ((thr_sel ? vcc_code : rssi_code) > rssi_thr);
      inwin  = (m_meas >= int'(win_lo)) && (m_meas <= int'(win_hi));
      start  = rx_en && m_done && inwin && m_pass && !m_valid;
      if (!rx_en) m_valid = 0;
      else if (m_done) m_valid = inwin && m_pass;
      if (!rx_en) begin m_wake = 1; m_pc = 0; end
      else if (start) begin m_pc = PULSE - 1; m_wake = 0; end
      else if (m_pc != 0) m_pc = m_pc - 1;
      else m_wake = 1;
      if (!rx_en) begin m_age = 0; m_armed = 0; end
      else if (!m_armed) begin
        if (m_age == SETTLE - 1) m_armed = 1;
        m_age = m_age + 1;
      end
      m_done = n_done; m_w = n_w; m_run = n_run; m_meas = n_meas; m_pass = n_pass;
      q.push_back(int'(data_in));
      void'(q.pop_front());
    end
  end

  // per-cycle comparison and monitors, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (data_valid !== m_valid) begin
        fails++;
        $display("FAIL R3 cycle %0d data_valid actual %0b expected %0b", cyc, data_valid, m_valid);
      end
      checks++;
      if (wake_n !== m_wake) begin
        fails++;
        $display("FAIL R7 cycle %0d wake_n actual %0b expected %0b", cyc, wake_n, m_wake);
      end
      if (data_valid && first_valid < 0) first_valid = cyc;
      if (!wake_n) low_run++;
      else begin
        if (low_run > 0) last_low = low_run;
        low_run = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind 0: all ones, 1: alternating 1010, 2: line held
  task automatic send(input int kind, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      bit b;
      if (kind == 2) begin
        repeat (2 * HB) @(negedge clk);
      end else begin
        b = (kind == 0) ? 1'b1 : ((i % 2) == 0);
        data_in = ~b;
        repeat (HB) @(negedge clk);
        data_in = b;
        repeat (HB) @(negedge clk);
      end
    end
  endtask

  int mark;
  task automatic run_case(input bit mh, input int lo, input int hi, input int rs,
                          input int vc, input bit sel, input int th, input int kind,
                          input int nbits);
    rx_en = 0;
    repeat (3) @(negedge clk);
    meas_high = mh; win_lo = CW'(lo); win_hi = CW'(hi);
    rssi_code = 6'(rs); vcc_code = 6'(vc); thr_sel = sel; rssi_thr = 6'(th);
    first_valid = -1;
    rx_en = 1;
    mark = cyc;
    send(kind, nbits);
  endtask

  initial begin
    rst = 1; rx_en = 0; data_in = 0; meas_high = 0; thr_sel = 0;
    win_lo = '0; win_hi = '0; rssi_code = '0; vcc_code = '0; rssi_thr = 6'h3f;
    repeat (5) @(negedge clk);
    chk("R12 valid after reset", int'(data_valid), 0);
    chk("R12 wake_n after reset", int'(wake_n), 1);
    rst = 0;

    // R1: preamble in window, strength above threshold
    run_case(0, 60, 70, 40, 0, 0, 30, 0, 12);
    chk("R1 valid with both tests passing", int'(data_valid), 1);
    chk("R4 no valid before settle", int'(first_valid - mark >= SETTLE), 1);
    chk("R4 valid soon after settle", int'(first_valid - mark <= SETTLE + 200), 1);
    chk("R7 wake pulse width", last_low, PULSE);
    // R3: freeze data, drop strength: flag must hold
    rssi_code = 6'd5;
    send(2, 6);
    chk("R3 hold without completions", int'(data_valid), 1);
    send(0, 6);
    chk("R3 falls at next completions", int'(data_valid), 0);

    run_case(0, 60, 70, 20, 0, 0, 30, 0, 10);
    chk("R5 level below threshold", int'(data_valid), 0);
    run_case(0, 60, 70, 30, 0, 0, 30, 0, 10);
    chk("R5 level equal to threshold", int'(data_valid), 0);
    run_case(0, 60, 70, 31, 0, 0, 30, 0, 10);
    chk("R5 level one above threshold", int'(data_valid), 1);

    run_case(0, 60, 70, 0, 0, 0, 63, 0, 10);
    chk("R6 all-ones threshold bypass", int'(data_valid), 1);

    run_case(0, 60, 70, 0, 50, 1, 30, 0, 10);
    chk("R8 supply level selected high", int'(data_valid), 1);
    run_case(0, 60, 70, 60, 10, 1, 30, 0, 10);
    chk("R8 supply level selected low", int'(data_valid), 0);

    run_case(0, 64, 64, 40, 0, 0, 30, 0, 10);
    chk("R9 count on both limits", int'(data_valid), 1);
    run_case(0, 65, 70, 40, 0, 0, 30, 0, 10);
    chk("R9 count one below lower", int'(data_valid), 0);
    run_case(0, 50, 63, 40, 0, 0, 30, 0, 10);
    chk("R9 count one above upper", int'(data_valid), 0);

    run_case(1, 32, 32, 40, 0, 0, 30, 0, 10);
    chk("R10 high-time measure", int'(data_valid), 1);
    run_case(1, 60, 70, 40, 0, 0, 30, 0, 10);
    chk("R10 high time outside window", int'(data_valid), 0);

    run_case(0, 60, 70, 40, 0, 0, 30, 1, 10);
    chk("R2 128-cycle period fails 60..70", int'(data_valid), 0);
    run_case(0, 120, 130, 40, 0, 0, 30, 1, 10);
    chk("R2 128-cycle period passes 120..130", int'(data_valid), 1);

    run_case(0, 60, 70, 40, 0, 0, 30, 0, 10);
    chk("R11 valid before rx drop", int'(data_valid), 1);
    rx_en = 0;
    @(negedge clk);
    chk("R11 valid cleared", int'(data_valid), 0);
    chk("R11 wake_n released", int'(wake_n), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule